// File: doc/BRIEF.md
# Two-Line Character Display Controller Core

This block is the device side of a character display controller. A host issues bus cycles, each made of a register-select bit, a read/write bit and an 8-bit data byte. The core keeps an address counter, an 80-byte display RAM that holds character codes, and a 64-byte pattern RAM that holds user-defined glyph rows. It decodes instruction bytes and executes them, and it holds a busy indication for each instruction's execution time. That time is counted in clock cycles and set by parameters. The host can read back the status byte and the contents of either RAM.

Host cycles arrive on a valid/ready request channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Status reads and RAM reads answer on a valid/ready response channel one cycle after they are taken. Only one response may be outstanding. `req_ready` stays low from the cycle a response becomes valid until the edge where `rsp_ready` takes it, and `rsp_data` holds steady while it waits. Every request other than a status read is refused while the core is busy. A refused request changes no state and sets a sticky error flag that only reset clears.

The display RAM addresses are 7 bits wide. In two-line mode, line 1 occupies 0x00–0x27 and line 2 occupies 0x40–0x67. In one-line mode, the 80 codes sit at 0x00–0x4F. Character codes 0x00–0x0F are the ones that select user patterns. Pixel generation itself lies outside this core.

Top module: `chardisp_core`

## Requirements
- R1: After reset: `busy`=0, `err_sticky`=0, `disp_ofs`=0, `ent_up`=1, `ent_shift`=0, `dsp_on`=`cur_on`=`blk_on`=0, `fn_wide`=1, `fn_two`=1, `fn_tall`=0, and a status read returns 0x00.
- R2: A status read (rs=0, rw=1) is accepted even while busy. It does not start a busy period. One cycle later it answers `{busy, address[6:0]}`, with the busy bit in bit 7.
- R3: An instruction byte is decoded by its highest set bit: bit7 sets the display address to bits[6:0]; bit6 sets the pattern address to bits[5:0]; bit5 is function set; bit4 is shift; bit3 is display control; bit2 is entry mode; bit1 is return home; bit0 is clear. The byte 0x00 does nothing and causes no busy period.
- R4: Clear fills all 80 display RAM bytes with 0x20, sets the address to 0x00, selects display RAM and sets `disp_ofs` to 0.
- R5: Return home sets the address to 0x00, selects display RAM and sets `disp_ofs` to 0. It leaves both RAMs unchanged.
- R6: After an accepted command, `busy` stays high for exactly CLR_CYC cycles for clear and home, SHORT_CYC cycles for the other instructions, and RAM_CYC cycles for a data read or data write.
- R7: A request other than a status read that arrives while busy is ignored. The address, the RAM contents and the modes stay as they were, and `err_sticky` becomes 1 and stays 1.
- R8: A data write (rs=1, rw=0) stores the byte at the address, and a data read (rs=1, rw=1) returns the byte at the address. After either one, the address steps up when `ent_up`=1 and down when it is 0.
- R9: Display-address stepping in two-line mode runs 0x27→0x40 and 0x67→0x00, and the reverse when stepping down. In one-line mode it wraps 0x4F↔0x00.
- R10: Pattern addresses are 6 bits and wrap 0x3F↔0x00. The RAM chosen by the last set-address instruction stays the target of data accesses until another set-address, clear or home instruction.
- R11: Entry mode loads `ent_up`/`ent_shift` from bits 1/0. Display control loads `dsp_on`/`cur_on`/`blk_on` from bits 2/1/0. Function set loads `fn_wide`/`fn_two`/`fn_tall` from bits 4/3/2.
- R12: The shift instruction uses bit3 to choose its target and bit2 to choose its direction (1 = up). With bit3=0 it steps the address. With bit3=1 it steps `disp_ofs` modulo 40. Neither RAM changes.
- R13: When `ent_shift`=1, each display RAM data write also steps `disp_ofs` in the `ent_up` direction. Pattern RAM writes leave `disp_ofs` unchanged.
- R14: While `rsp_valid`=1, `req_ready`=0. A response that is not taken keeps `rsp_valid` and `rsp_data` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host cycle present |
| req_ready | output | 1 | Core can take a host cycle |
| req_rs | input | 1 | 0 = instruction/status, 1 = RAM data |
| req_rw | input | 1 | 0 = write, 1 = read |
| req_data | input | 8 | Instruction or data byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Status byte or RAM byte |
| busy | output | 1 | Command in execution |
| err_sticky | output | 1 | A request was refused while busy |
| ent_up | output | 1 | Address steps up after data access |
| ent_shift | output | 1 | Display offset follows data writes |
| dsp_on | output | 1 | Display enabled |
| cur_on | output | 1 | Cursor shown |
| blk_on | output | 1 | Cursor blinks |
| fn_wide | output | 1 | 8-bit host bus mode |
| fn_two | output | 1 | Two-line mode |
| fn_tall | output | 1 | Tall glyph font |
| disp_ofs | output | 6 | Display window offset, 0..39 |

## Verification
The bench drives the address counter across the line seams at 0x27/0x40 and 0x67/0x00, in both directions, and across the one-line wrap and the pattern-RAM wrap. A design that steps linearly would report 0x28 or 0x68 in the status byte. It sends instruction bytes that have several bits set, such as 0xFF and 0x03. A decoder that gives priority to the wrong bit would execute a different instruction. It sends writes while the core is busy. A design that does not gate on busy would change the address or the RAM and would leave the error flag clear. It also measures every busy period against its exact cycle count, reads the last display byte to confirm that clear fills it, and holds back `rsp_ready` to catch a response that is lost or changed.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  localparam int AC_W = 7;

  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADDR, OP_DDADDR
  } op_e;

  typedef struct packed {
    logic            ok;
    logic [AC_W-1:0] idx;
  } dd_loc_t;

  // Map a display address onto a linear storage index.
  function automatic dd_loc_t dd_locate(input logic [AC_W-1:0] a, input logic two,
                                        input int span, input int bytes);
    dd_loc_t r;
    if (two) begin
      r.ok  = ({1'b0, a[5:0]} < AC_W'(span));
      r.idx = a[6] ? AC_W'({1'b0, a[5:0]} + AC_W'(span)) : {1'b0, a[5:0]};
    end else begin
      r.ok  = 1'b1;
      r.idx = a;
    end
    r.ok = r.ok && (r.idx < AC_W'(bytes));
    return r;
  endfunction

  // Next address after a step, wrapping inside the selected RAM.
  function automatic logic [AC_W-1:0] ac_step(input logic [AC_W-1:0] a, input logic cg,
                                              input logic up, input logic two,
                                              input int span, input int bytes,
                                              input int cgb);
    logic [AC_W-1:0] r;
    if (cg) begin
      if (up) r = (a == AC_W'(cgb - 1)) ? '0 : a + 1'b1;
      else    r = (a == '0) ? AC_W'(cgb - 1) : a - 1'b1;
    end else if (two) begin
      if (up) begin
        if (a == AC_W'(span - 1))             r = 7'h40;
        else if (a == AC_W'(64 + span - 1))   r = '0;
        else                                  r = a + 1'b1;
      end else begin
        if (a == '0)                          r = AC_W'(64 + span - 1);
        else if (a == 7'h40)                  r = AC_W'(span - 1);
        else                                  r = a - 1'b1;
      end
    end else begin
      if (up) r = (a == AC_W'(bytes - 1)) ? '0 : a + 1'b1;
      else    r = (a == '0) ? AC_W'(bytes - 1) : a - 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
  import chardisp_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  logic [2:0] top_bit;
  logic       any_bit;

  always_comb begin
    top_bit = '0;
    any_bit = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (code[i]) begin
        top_bit = 3'(i);
        any_bit = 1'b1;
      end
    end
  end

  always_comb begin
    op = OP_NOP;
    if (any_bit) begin
      unique case (top_bit)
        3'd7: op = OP_DDADDR;
        3'd6: op = OP_CGADDR;
        3'd5: op = OP_FUNC;
        3'd4: op = OP_SHIFT;
        3'd3: op = OP_DISP;
        3'd2: op = OP_ENTRY;
        3'd1: op = OP_HOME;
        default: op = OP_CLEAR;
      endcase
    end
  end
endmodule

// File: rtl/chardisp_busy.sv
module chardisp_busy #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/chardisp_mem.sv
module chardisp_mem
  import chardisp_pkg::*;
#(
  parameter int DD_BYTES  = 80,
  parameter int CG_BYTES  = 64,
  parameter int LINE_SPAN = 40,
  parameter logic [7:0] BLANK = 8'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_go,
  input  logic            wr_en,
  input  logic            sel_cg,
  input  logic            two_line,
  input  logic [AC_W-1:0] ac,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data
);
  localparam int CG_W = $clog2(CG_BYTES);
  localparam int DD_W = $clog2(DD_BYTES);

  logic [7:0] dd_mem [DD_BYTES];
  logic [7:0] cg_mem [CG_BYTES];

  logic            clr_act;
  logic [DD_W-1:0] clr_ptr;
  dd_loc_t         loc;
  logic [CG_W-1:0] cg_idx;

  assign loc    = dd_locate(ac, two_line, LINE_SPAN, DD_BYTES);
  assign cg_idx = ac[CG_W-1:0];

  // Clear walks one display byte per cycle while the core is busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_act <= 1'b0;
      clr_ptr <= '0;
    end else if (clr_go) begin
      clr_act <= 1'b1;
      clr_ptr <= '0;
    end else if (clr_act) begin
      if (clr_ptr == DD_W'(DD_BYTES - 1)) clr_act <= 1'b0;
      else                                clr_ptr <= clr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_act)
      dd_mem[clr_ptr] <= BLANK;
    else if (wr_en && !sel_cg && loc.ok)
      dd_mem[DD_W'(loc.idx)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && sel_cg)
      cg_mem[cg_idx] <= wr_data;
  end

  always_comb begin
    if (sel_cg)      rd_data = cg_mem[cg_idx];
    else if (loc.ok) rd_data = dd_mem[DD_W'(loc.idx)];
    else             rd_data = 8'h00;
  end
endmodule

// File: rtl/chardisp_core.sv
module chardisp_core
  import chardisp_pkg::*;
#(
  parameter int DD_BYTES  = 80,
  parameter int CG_BYTES  = 64,
  parameter int LINE_SPAN = 40,
  parameter int CLR_CYC   = 100,
  parameter int SHORT_CYC = 8,
  parameter int RAM_CYC   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic [7:0] req_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       busy,
  output logic       err_sticky,
  output logic       ent_up,
  output logic       ent_shift,
  output logic       dsp_on,
  output logic       cur_on,
  output logic       blk_on,
  output logic       fn_wide,
  output logic       fn_two,
  output logic       fn_tall,
  output logic [5:0] disp_ofs
);
  localparam int CLR_EFF = (CLR_CYC < DD_BYTES) ? DD_BYTES : CLR_CYC;
  localparam int MAXC_A  = (CLR_EFF > SHORT_CYC) ? CLR_EFF : SHORT_CYC;
  localparam int MAXC    = (MAXC_A > RAM_CYC) ? MAXC_A : RAM_CYC;
  localparam int CNT_W   = $clog2(MAXC + 1);
  localparam int OFS_W   = 6;

  logic [AC_W-1:0]  ac_q;
  logic             cg_sel;
  logic [OFS_W-1:0] ofs_q;
  logic             rsp_v_q;
  logic [7:0]       rsp_d_q;
  logic             err_q;
  logic             up_q, sh_q, dsp_q, cur_q, blk_q, wide_q, two_q, tall_q;

  op_e              op;
  logic             acc, is_status, go, go_instr, go_data;
  logic             mem_wr, clr_go, busy_load;
  logic [CNT_W-1:0] busy_val;
  logic [7:0]       mem_rd;
  logic [AC_W-1:0]  ac_stepped;

  function automatic logic [OFS_W-1:0] ofs_step(input logic [OFS_W-1:0] o, input logic up);
    if (up) return (o == OFS_W'(LINE_SPAN - 1)) ? '0 : o + 1'b1;
    else    return (o == '0) ? OFS_W'(LINE_SPAN - 1) : o - 1'b1;
  endfunction

  chardisp_decode u_dec (.code(req_data), .op(op));

  assign req_ready = !rsp_v_q;
  assign acc       = req_valid && req_ready;
  assign is_status = !req_rs && req_rw;
  assign go        = acc && !busy && !is_status;
  assign go_instr  = go && !req_rs;
  assign go_data   = go && req_rs;
  assign mem_wr    = go_data && !req_rw;
  assign clr_go    = go_instr && (op == OP_CLEAR);

  // Step direction for data accesses, or the shift-instruction direction.
  assign ac_stepped = ac_step(ac_q, cg_sel, go_data ? up_q : req_data[2], two_q,
                              LINE_SPAN, DD_BYTES, CG_BYTES);

  always_comb begin
    busy_load = 1'b0;
    busy_val  = '0;
    if (go_data) begin
      busy_load = 1'b1;
      busy_val  = CNT_W'(RAM_CYC);
    end else if (go_instr && op != OP_NOP) begin
      busy_load = 1'b1;
      busy_val  = (op == OP_CLEAR || op == OP_HOME) ? CNT_W'(CLR_EFF) : CNT_W'(SHORT_CYC);
    end
  end

  chardisp_busy #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(busy_load), .load_val(busy_val), .busy(busy)
  );

  chardisp_mem #(.DD_BYTES(DD_BYTES), .CG_BYTES(CG_BYTES), .LINE_SPAN(LINE_SPAN)) u_mem (
    .clk(clk), .rst_n(rst_n), .clr_go(clr_go), .wr_en(mem_wr), .sel_cg(cg_sel),
    .two_line(two_q), .ac(ac_q), .wr_data(req_data), .rd_data(mem_rd)
  );

  // Response channel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else if (acc && is_status) begin
      rsp_v_q <= 1'b1;
      rsp_d_q <= {busy, ac_q};
    end else if (go_data && req_rw) begin
      rsp_v_q <= 1'b1;
      rsp_d_q <= mem_rd;
    end else if (rsp_v_q && rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (acc && busy && !is_status) err_q <= 1'b1;
  end

  // Address counter, RAM selection and display offset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q   <= '0;
      cg_sel <= 1'b0;
      ofs_q  <= '0;
    end else if (go_data) begin
      ac_q <= ac_stepped;
      if (!req_rw && !cg_sel && sh_q) ofs_q <= ofs_step(ofs_q, up_q);
    end else if (go_instr) begin
      unique case (op)
        OP_CLEAR, OP_HOME: begin
          ac_q   <= '0;
          cg_sel <= 1'b0;
          ofs_q  <= '0;
        end
        OP_SHIFT: begin
          if (req_data[3]) ofs_q <= ofs_step(ofs_q, req_data[2]);
          else             ac_q  <= ac_stepped;
        end
        OP_CGADDR: begin
          cg_sel <= 1'b1;
          ac_q   <= {1'b0, req_data[5:0]};
        end
        OP_DDADDR: begin
          cg_sel <= 1'b0;
          ac_q   <= req_data[6:0];
        end
        default: ;
      endcase
    end
  end

  // Mode registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b1; sh_q <= 1'b0;
      dsp_q <= 1'b0; cur_q <= 1'b0; blk_q <= 1'b0;
      wide_q <= 1'b1; two_q <= 1'b1; tall_q <= 1'b0;
    end else if (go_instr) begin
      case (op)
        OP_ENTRY: begin up_q <= req_data[1]; sh_q <= req_data[0]; end
        OP_DISP:  begin dsp_q <= req_data[2]; cur_q <= req_data[1]; blk_q <= req_data[0]; end
        OP_FUNC:  begin wide_q <= req_data[4]; two_q <= req_data[3]; tall_q <= req_data[2]; end
        default: ;
      endcase
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_data   = rsp_d_q;
  assign err_sticky = err_q;
  assign ent_up     = up_q;
  assign ent_shift  = sh_q;
  assign dsp_on     = dsp_q;
  assign cur_on     = cur_q;
  assign blk_on     = blk_q;
  assign fn_wide    = wide_q;
  assign fn_two     = two_q;
  assign fn_tall    = tall_q;
  assign disp_ofs   = ofs_q;
endmodule

// File: rtl/chardisp_sva.sv
module chardisp_sva #(
  parameter int DD_BYTES  = 80,
  parameter int LINE_SPAN = 40,
  parameter int CLR_CYC   = 100,
  parameter int SHORT_CYC = 8,
  parameter int RAM_CYC   = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_rs,
  input logic       req_rw,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       busy,
  input logic       err_sticky,
  input logic [5:0] disp_ofs,
  input logic [6:0] ac_q,
  input logic       cg_sel
);
  localparam int CLR_EFF = (CLR_CYC < DD_BYTES) ? DD_BYTES : CLR_CYC;

  logic [15:0] blen;
  logic        taken_stat, taken_other;

  assign taken_stat  = req_valid && req_ready && !req_rs && req_rw;
  assign taken_other = req_valid && req_ready && !(!req_rs && req_rw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  blen <= '0;
    else if (busy && blen != '1) blen <= blen + 1'b1;
    else if (!busy)              blen <= '0;
  end

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |->
      (blen == 16'(SHORT_CYC) || blen == 16'(RAM_CYC) || blen == 16'(CLR_EFF)));

  a_r2_status_reply: assert property (@(posedge clk) disable iff (!rst_n)
    taken_stat |=> rsp_valid && rsp_data == {$past(busy), $past(ac_q)});

  a_r7_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_other && busy) |=> err_sticky && $stable(ac_q) && $stable(cg_sel));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  a_r14_hold_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

  a_r14_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r10_cg_addr_width: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> !ac_q[6]);

  a_r12_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ofs < 6'(LINE_SPAN));
endmodule

bind chardisp_core chardisp_sva #(
  .DD_BYTES(DD_BYTES), .LINE_SPAN(LINE_SPAN), .CLR_CYC(CLR_CYC),
  .SHORT_CYC(SHORT_CYC), .RAM_CYC(RAM_CYC)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_rs(req_rs), .req_rw(req_rw), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .busy(busy), .err_sticky(err_sticky), .disp_ofs(disp_ofs),
  .ac_q(ac_q), .cg_sel(cg_sel)
);

// File: tb/chardisp_core_tb.sv
`timescale 1ns/1ps
module chardisp_core_tb_top;
  localparam int CLR_N = 100;
  localparam int SHT_N = 8;
  localparam int RAM_N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0;
  logic [7:0] req_data = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, busy, err_sticky;
  logic ent_up, ent_shift, dsp_on, cur_on, blk_on, fn_wide, fn_two, fn_tall;
  logic [7:0] rsp_data;
  logic [5:0] disp_ofs;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  chardisp_core #(.CLR_CYC(CLR_N), .SHORT_CYC(SHT_N), .RAM_CYC(RAM_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .busy(busy), .err_sticky(err_sticky),
    .ent_up(ent_up), .ent_shift(ent_shift), .dsp_on(dsp_on), .cur_on(cur_on),
    .blk_on(blk_on), .fn_wide(fn_wide), .fn_two(fn_two), .fn_tall(fn_tall),
    .disp_ofs(disp_ofs)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops an expected byte for every response taken.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R14 unexpected response actual=0x%0h expected=none", rsp_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_rs = rs; req_rw = rw; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic count_busy(input int exp, input string tag);
    int n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == exp, tag, n, exp);
  endtask

  task automatic instr(input logic [7:0] d, input int exp, input string tag);
    xfer(1'b0, 1'b0, d);
    count_busy(exp, tag);
  endtask

  task automatic expect_rsp(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic status(input logic [7:0] v, input string tag);
    expect_rsp(v, tag);
    xfer(1'b0, 1'b1, 8'h00);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] v, input string tag);
    expect_rsp(v, tag);
    xfer(1'b1, 1'b1, 8'h00);
    count_busy(RAM_N, "R6 read busy");
  endtask

  task automatic wr(input logic [7:0] d);
    xfer(1'b1, 1'b0, d);
    count_busy(RAM_N, "R6 write busy");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !err_sticky && disp_ofs == 0, "R1 busy/err/ofs", {busy, err_sticky, disp_ofs}, 0);
    check({ent_up, ent_shift, dsp_on, cur_on, blk_on} == 5'b10000, "R1 entry/display",
          {ent_up, ent_shift, dsp_on, cur_on, blk_on}, 5'b10000);
    check({fn_wide, fn_two, fn_tall} == 3'b110, "R1 function", {fn_wide, fn_two, fn_tall}, 3'b110);
    status(8'h00, "R1 status after reset");

    // R4 clear, R6 long busy
    instr(8'h01, CLR_N, "R4 R6 clear busy");
    // R2 status during busy
    xfer(1'b0, 1'b0, 8'h01);
    status(8'h80, "R2 status while busy");
    while (busy) @(negedge clk);
    instr(8'hE7, SHT_N, "R6 set address busy");
    rd(8'h20, "R4 last display byte blank");
    instr(8'h80, SHT_N, "R3 set display 0");
    rd(8'h20, "R4 first display byte blank");

    // R8 R9 two-line stepping over the seam
    instr(8'hA6, SHT_N, "R3 set 0x26");
    wr(8'h41); wr(8'h42); wr(8'h43);
    status(8'h41, "R9 0x27 to 0x40 seam");
    instr(8'hA6, SHT_N, "R3 set 0x26");
    rd(8'h41, "R8 read back 0x26");
    rd(8'h42, "R8 read back 0x27");
    rd(8'h43, "R8 read back 0x40");
    instr(8'hE7, SHT_N, "R3 set 0x67");
    wr(8'h55);
    status(8'h00, "R9 0x67 to 0x00 wrap");

    // R9 stepping down
    instr(8'h04, SHT_N, "R11 entry down");
    check(!ent_up, "R11 ent_up cleared", ent_up, 0);
    instr(8'h80, SHT_N, "R3 set 0");
    wr(8'h66);
    status(8'h67, "R9 0x00 down to 0x67");
    instr(8'hC0, SHT_N, "R3 set 0x40");
    rd(8'h43, "R8 read at 0x40");
    status(8'h27, "R9 0x40 down to 0x27");

    // R9 one-line wrap
    instr(8'h30, SHT_N, "R11 function one-line");
    check({fn_wide, fn_two, fn_tall} == 3'b100, "R11 function bits", {fn_wide, fn_two, fn_tall}, 3'b100);
    instr(8'h06, SHT_N, "R11 entry up");
    instr(8'hCF, SHT_N, "R3 set 0x4F");
    wr(8'h77);
    status(8'h00, "R9 one-line 0x4F wrap");
    instr(8'h38, SHT_N, "R11 function two-line");

    // R10 pattern RAM
    instr(8'h7F, SHT_N, "R3 set pattern 0x3F");
    wr(8'h1F);
    status(8'h00, "R10 pattern wrap 0x3F to 0");
    wr(8'h0A);
    instr(8'h7F, SHT_N, "R3 set pattern 0x3F");
    rd(8'h1F, "R10 pattern read 0x3F");
    status(8'h00, "R10 pattern addr after read");
    rd(8'h0A, "R10 pattern read 0x00");
    instr(8'h45, SHT_N, "R3 set pattern 0x05");
    instr(8'h0F, SHT_N, "R11 display ctrl");
    wr(8'h11);
    instr(8'h45, SHT_N, "R3 set pattern 0x05");
    rd(8'h11, "R10 selection persists");
    instr(8'h85, SHT_N, "R3 set display 5");
    rd(8'h20, "R10 display byte untouched");

    // R11 modes
    instr(8'h0D, SHT_N, "R11 display ctrl");
    check({dsp_on, cur_on, blk_on} == 3'b101, "R11 display bits", {dsp_on, cur_on, blk_on}, 3'b101);
    instr(8'h24, SHT_N, "R11 function set");
    check({fn_wide, fn_two, fn_tall} == 3'b001, "R11 function bits", {fn_wide, fn_two, fn_tall}, 3'b001);
    instr(8'h38, SHT_N, "R11 function restore");

    // R3 priority, R5 home
    instr(8'h85, SHT_N, "R3 set display 5");
    instr(8'h03, CLR_N, "R3 R5 0x03 is home");
    status(8'h00, "R5 home address");
    instr(8'h00, 0, "R3 zero byte no busy");
    check(!err_sticky, "R3 zero byte no error", err_sticky, 0);
    instr(8'hFF, SHT_N, "R3 0xFF is set display");
    status(8'h7F, "R3 0xFF address");

    // R12 shift
    instr(8'h85, SHT_N, "R3 set display 5");
    instr(8'h14, SHT_N, "R12 cursor up");
    status(8'h06, "R12 cursor up address");
    instr(8'h10, SHT_N, "R12 cursor down");
    status(8'h05, "R12 cursor down address");
    instr(8'h1C, SHT_N, "R12 display up");
    check(disp_ofs == 1, "R12 offset up", disp_ofs, 1);
    instr(8'h18, SHT_N, "R12 display down");
    instr(8'h18, SHT_N, "R12 display down");
    check(disp_ofs == 39, "R12 offset wrap", disp_ofs, 39);
    instr(8'h02, CLR_N, "R5 home");
    check(disp_ofs == 0, "R5 home offset", disp_ofs, 0);
    instr(8'hA6, SHT_N, "R3 set 0x26");
    rd(8'h41, "R5 home keeps RAM");

    // R13 entry shift
    instr(8'h07, SHT_N, "R13 entry up+shift");
    instr(8'h80, SHT_N, "R3 set 0");
    wr(8'h31);
    check(disp_ofs == 1, "R13 write shifts up", disp_ofs, 1);
    instr(8'h05, SHT_N, "R13 entry down+shift");
    wr(8'h32);
    check(disp_ofs == 0, "R13 write shifts down", disp_ofs, 0);
    instr(8'h07, SHT_N, "R13 entry up+shift");
    instr(8'h40, SHT_N, "R3 set pattern 0");
    wr(8'h0E);
    check(disp_ofs == 0, "R13 pattern write no shift", disp_ofs, 0);

    // R4 clear resets offset and contents
    instr(8'h1C, SHT_N, "R12 display up");
    instr(8'h01, CLR_N, "R4 clear");
    check(disp_ofs == 0, "R4 clear offset", disp_ofs, 0);
    instr(8'h06, SHT_N, "R11 entry up");
    instr(8'hA6, SHT_N, "R3 set 0x26");
    rd(8'h20, "R4 clear overwrote 0x26");

    // R7 refusal while busy
    check(!err_sticky, "R7 no error yet", err_sticky, 0);
    instr(8'h80, SHT_N, "R3 set 0");
    xfer(1'b1, 1'b0, 8'h99);
    xfer(1'b1, 1'b0, 8'h44);
    @(negedge clk);
    check(err_sticky, "R7 error flag set", err_sticky, 1);
    while (busy) @(negedge clk);
    status(8'h01, "R7 address unchanged by refused write");
    instr(8'h81, SHT_N, "R3 set 1");
    expect_rsp(8'h20, "R7 refused write left RAM");
    xfer(1'b1, 1'b1, 8'h00);
    xfer(1'b0, 1'b0, 8'hC5);
    while (busy) @(negedge clk);
    status(8'h02, "R7 refused set-address");
    check(err_sticky, "R7 error stays", err_sticky, 1);

    // R14 back-pressure
    rsp_ready = 1'b0;
    xfer(1'b0, 1'b1, 8'h00);
    check(rsp_valid && !req_ready, "R14 pending blocks requests", {rsp_valid, req_ready}, 2'b10);
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_data == 8'h02, "R14 response held", rsp_data, 8'h02);
    expect_rsp(8'h02, "R14 held response taken");
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(!rsp_valid && req_ready, "R14 released", {rsp_valid, req_ready}, 2'b01);
    check(exp_q.size() == 0, "R14 scoreboard drained", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule